// File: doc/BRIEF.md
# Same-Frame SPI Command Slave with Frame-Length Guard

This block terminates a 24-bit SPI link from a host controller and turns each frame into one register action. The first byte the host sends is a command: a two-bit operation code and a six-bit register address. The last two bytes carry write data. In the same frame the block sends back a global status byte while the command is arriving, followed by sixteen bits of data picked by that command. All SPI pins are brought into the system clock through two-flop synchronisers, so SCLK must be slow compared with the system clock (at least four system clocks per SCLK phase).

On the register side the block drives an address, a write strobe with write data, and a clear strobe for status registers. It samples the addressed register through a combinational read port, and takes five fault inputs that feed the status byte. A write or clear happens only when chip select rises after exactly 24 SCLK rising edges. Any other non-zero count throws the frame away and raises a transfer-fault flag. A frame with no clocks at all only lets the host look at the fault summary on the data output. A frame of all ones is taken to mean a stuck data line: it drops the reset-acknowledge bit and raises a one-cycle output-kill pulse.

Top module: `spi24_frame_slave`

## Requirements
- R1: At most one of `reg_wr`, `stat_clr` and `frame_rst` pulses for any one frame, and each pulse lasts one system clock. Frames travel MSB first: bits 23:22 hold the operation, bits 21:16 the address and bits 15:0 the data.
- R2: `sdo_oe` is low while chip select is high. Once chip select is low and before the first SCLK edge, `sdo` shows the fault summary bit FLT.
- R3: The reply's upper byte is the status byte. From bit 23 down it holds FLT, TF, RESB, then `fault_flags[4:0]`. FLT is the OR of TF, the inverse of RESB and the five fault inputs. After reset, with `fault_flags`=00001, it reads 81 hex.
- R4: Operation 00 (write) returns the register's previous contents from `reg_rdata` in bits 15:0. It then pulses `reg_wr` with `reg_addr` and `reg_wdata` taken from the frame.
- R5: Operation 01 (read) returns `reg_rdata` for the addressed register and produces no strobe.
- R6: Operation 10 (read-and-clear) returns `reg_rdata` and then pulses `stat_clr` for that address.
- R7: Operation 11 (identification) returns an 8-bit value in bits 15:8 and zero in bits 7:0. Address 3E hex gives 02 hex and every other address gives 00. No strobe is produced.
- R8: A frame with a clock count other than 0 or 24 (including 25) produces no strobe and sets TF. TF shows up in the next frame's status byte and is cleared when the next 24-clock frame ends.
- R9: A frame with zero clocks changes neither TF nor RESB and produces no strobe.
- R10: A 24-clock frame of all ones clears RESB (so FLT reads 1), pulses `frame_rst` and produces no write.
- R11: Any other 24-clock frame sets RESB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI shift clock |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for the tri-state `sdo` pad |
| reg_addr | output | 6 | Address of the register in the current command |
| reg_wdata | output | 16 | Write data of the last complete frame |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Combinational read data for `reg_addr` |
| stat_clr | output | 1 | One-cycle read-and-clear strobe |
| frame_rst | output | 1 | One-cycle pulse after an all-ones frame |
| fault_flags | input | 5 | Fault inputs, bit 4 down to 0 |

## Verification
Two things meet at the close of a 24-clock frame. The TF bit is sent in that frame's status byte and is cleared on the chip-select edge that commits the same frame. The bench provokes this by following a 10-clock frame, and then a 25-clock frame, with a full read. It expects TF set in the reply and cleared in the reply after that. An all-ones frame is both a well-formed 24-clock frame, which clears TF, and a stuck-line reset, which clears RESB. The bench judges that pair from the next reply's status byte (80 hex) and from the strobe counters.

// File: rtl/spi24_pkg.sv
package spi24_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_RDCLR = 2'b10,
    OP_IDENT = 2'b11
  } op_e;

  localparam int ADDR_W   = 6;
  localparam int CMD_BITS = 8;
  localparam int FLAG_W   = 5;

  localparam logic [ADDR_W-1:0] WIDTH_ID_ADDR = 6'h3E;
  localparam logic [7:0]        WIDTH_ID_CODE = 8'h02;

  function automatic logic [7:0] ident_byte(input logic [ADDR_W-1:0] a);
    return (a == WIDTH_ID_ADDR) ? WIDTH_ID_CODE : 8'h00;
  endfunction
endpackage

// File: rtl/spi24_sync.sv
module spi24_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi24_status.sv
module spi24_status #(
  parameter int FLAG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_tf,
  input  logic              clr_tf,
  input  logic              set_resb,
  input  logic              clr_resb,
  input  logic [FLAG_W-1:0] flags,
  output logic [FLAG_W+2:0] status
);
  logic tf_q, tf_d, resb_q, resb_d, flt;

  always_comb begin
    tf_d = tf_q;
    if (set_tf)      tf_d = 1'b1;
    else if (clr_tf) tf_d = 1'b0;
    resb_d = resb_q;
    if (clr_resb)      resb_d = 1'b0;
    else if (set_resb) resb_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tf_q   <= 1'b0;
      resb_q <= 1'b0;
    end else begin
      tf_q   <= tf_d;
      resb_q <= resb_d;
    end
  end

  assign flt    = tf_q | ~resb_q | (|flags);
  assign status = {flt, tf_q, resb_q, flags};

  a_r8_tf_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tf_q) |-> $past(set_tf));
endmodule

// File: rtl/spi24_tx.sv
module spi24_tx #(
  parameter int FB = 24,
  parameter int DB = 16,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          fall,
  input  logic          load_stat,
  input  logic [7:0]    stat,
  input  logic          load_data,
  input  logic [DB-1:0] data,
  input  logic          live_flt,
  output logic          sdo
);
  logic [FB-1:0] word_q, word_d;
  logic [CW-1:0] nfall_q, nfall_d, idx;
  logic          started_q, started_d;

  always_comb begin
    word_d    = word_q;
    nfall_d   = nfall_q;
    started_d = started_q;
    if (load_stat) word_d[FB-1 -: 8] = stat;
    if (load_data) word_d[DB-1:0]    = data;
    if (clear) begin
      nfall_d   = '0;
      started_d = 1'b0;
    end else begin
      if (load_stat) started_d = 1'b1;
      if (fall && nfall_q != CW'(FB)) nfall_d = nfall_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= '0;
      nfall_q   <= '0;
      started_q <= 1'b0;
    end else begin
      word_q    <= word_d;
      nfall_q   <= nfall_d;
      started_q <= started_d;
    end
  end

  assign idx = CW'(FB - 1) - nfall_q;
  assign sdo = !started_q ? live_flt :
               (nfall_q < CW'(FB)) ? word_q[idx] : 1'b0;
endmodule

// File: rtl/spi24_frame_slave.sv
module spi24_frame_slave
  import spi24_pkg::*;
#(
  parameter int DATA_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 sdi,
  output logic                 sdo,
  output logic                 sdo_oe,
  output logic [ADDR_W-1:0]    reg_addr,
  output logic [DATA_BITS-1:0] reg_wdata,
  output logic                 reg_wr,
  input  logic [DATA_BITS-1:0] reg_rdata,
  output logic                 stat_clr,
  output logic                 frame_rst,
  input  logic [FLAG_W-1:0]    fault_flags
);
  localparam int FRAME_BITS = CMD_BITS + DATA_BITS;
  localparam int CNT_MAX    = FRAME_BITS + 1;
  localparam int CW         = $clog2(CNT_MAX + 1);

  logic cs_s, sclk_s, sdi_s, cs_q, sclk_q;
  logic rise, fall, cs_fall, cs_rise;

  spi24_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sclk, sdi}), .q({cs_s, sclk_s, sdi_s})
  );

  assign rise    = ~cs_s & sclk_s & ~sclk_q;
  assign fall    = ~cs_s & ~sclk_s & sclk_q;
  assign cs_fall = ~cs_s & cs_q;
  assign cs_rise = cs_s & ~cs_q;

  logic [CW-1:0]         nrise_q, nrise_d;
  logic [FRAME_BITS-1:0] rx_q, rx_d;
  logic [CMD_BITS-1:0]   cmd_q, cmd_d;
  logic [DATA_BITS-1:0]  wdata_q, wdata_d, rd_word;
  logic                  ld_q, ld_d, wr_q, wr_d, clr_q, clr_d, frst_q, frst_d;
  logic                  set_tf, clr_tf, set_resb, clr_resb;
  logic [FLAG_W+2:0]     stat;
  op_e                   op;

  assign op = op_e'(cmd_q[CMD_BITS-1 -: 2]);

  always_comb begin
    nrise_d  = nrise_q;
    rx_d     = rx_q;
    cmd_d    = cmd_q;
    wdata_d  = wdata_q;
    ld_d     = 1'b0;
    wr_d     = 1'b0;
    clr_d    = 1'b0;
    frst_d   = 1'b0;
    set_tf   = 1'b0;
    clr_tf   = 1'b0;
    set_resb = 1'b0;
    clr_resb = 1'b0;
    if (cs_fall) begin
      nrise_d = '0;
    end else if (rise) begin
      rx_d = {rx_q[FRAME_BITS-2:0], sdi_s};
      if (nrise_q != CW'(CNT_MAX)) nrise_d = nrise_q + 1'b1;
      if (nrise_q == CW'(CMD_BITS - 1)) begin
        cmd_d = {rx_q[CMD_BITS-2:0], sdi_s};
        ld_d  = 1'b1;
      end
    end
    if (cs_rise) begin
      if (nrise_q == CW'(FRAME_BITS)) begin
        clr_tf  = 1'b1;
        wdata_d = rx_q[DATA_BITS-1:0];
        if (&rx_q) begin
          clr_resb = 1'b1;
          frst_d   = 1'b1;
        end else begin
          set_resb = 1'b1;
          case (op)
            OP_WRITE: wr_d  = 1'b1;
            OP_RDCLR: clr_d = 1'b1;
            default:  ;
          endcase
        end
      end else if (nrise_q != '0) begin
        set_tf = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      nrise_q <= '0;
      rx_q    <= '0;
      cmd_q   <= '0;
      wdata_q <= '0;
      ld_q    <= 1'b0;
      wr_q    <= 1'b0;
      clr_q   <= 1'b0;
      frst_q  <= 1'b0;
    end else begin
      cs_q    <= cs_s;
      sclk_q  <= sclk_s;
      nrise_q <= nrise_d;
      rx_q    <= rx_d;
      cmd_q   <= cmd_d;
      wdata_q <= wdata_d;
      ld_q    <= ld_d;
      wr_q    <= wr_d;
      clr_q   <= clr_d;
      frst_q  <= frst_d;
    end
  end

  assign rd_word = (op == OP_IDENT) ?
                   {ident_byte(cmd_q[ADDR_W-1:0]), {(DATA_BITS-8){1'b0}}} : reg_rdata;

  spi24_status #(.FLAG_W(FLAG_W)) u_status (
    .clk(clk), .rst_n(rst_n),
    .set_tf(set_tf), .clr_tf(clr_tf), .set_resb(set_resb), .clr_resb(clr_resb),
    .flags(fault_flags), .status(stat)
  );

  spi24_tx #(.FB(FRAME_BITS), .DB(DATA_BITS), .CW(CW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .clear(cs_fall), .fall(fall),
    .load_stat(rise && nrise_q == '0), .stat(stat),
    .load_data(ld_q), .data(rd_word),
    .live_flt(stat[FLAG_W+2]), .sdo(sdo)
  );

  assign sdo_oe    = ~cs_s;
  assign reg_addr  = cmd_q[ADDR_W-1:0];
  assign reg_wdata = wdata_q;
  assign reg_wr    = wr_q;
  assign stat_clr  = clr_q;
  assign frame_rst = frst_q;

  a_r1_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_q, clr_q, frst_q}));

  a_r4_full_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q || clr_q || frst_q) |-> nrise_q == CW'(FRAME_BITS));

  a_r8_tf_on_bad_count: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && nrise_q != '0 && nrise_q != CW'(FRAME_BITS)) |=> stat[FLAG_W+1]);

  a_r10_resb_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    frst_q |-> !stat[FLAG_W]);

  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && cs_q) |-> !(wr_q && clr_q));
endmodule

// File: tb/sim_spi24_frame_slave.sv
module sim_spi24_frame_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic        sdo, sdo_oe, reg_wr, stat_clr, frame_rst;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [4:0]  flags = 5'b00001;
  logic [15:0] regs [64];

  int errors = 0, checks = 0;
  int n_wr = 0, n_clr = 0, n_rst = 0;
  logic m_tf = 1'b0, m_resb = 1'b0;
  logic [1:0] h;

  always #5 clk = ~clk;

  spi24_frame_slave u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .stat_clr(stat_clr),
    .frame_rst(frame_rst), .fault_flags(flags)
  );

  assign reg_rdata = regs[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 64; k++) regs[k] <= 16'hA000 | 16'(k);
      h <= 2'b11;
    end else begin
      h <= {h[0], cs_n};
      if (reg_wr)    begin regs[reg_addr] <= reg_wdata; n_wr++;  end
      if (stat_clr)  begin regs[reg_addr] <= 16'h0000;  n_clr++; end
      if (frame_rst) n_rst++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle reference: output enable follows chip select through two stages (R2)
  always @(negedge clk) if (rst_n) chk(sdo_oe == !h[1], "R2 sdo_oe per cycle", 32'(sdo_oe), 32'(!h[1]));

  function automatic logic [7:0] exp_stat();
    return {m_tf | ~m_resb | (|flags), m_tf, m_resb, flags};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [23:0] tx, input int nclk, output logic [23:0] rx);
    rx = '0;
    cs_n = 1'b0;
    if (nclk == 0) begin
      tick(8);
      rx[23] = sdo;
    end
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 24) ? tx[23-i] : 1'b0;
      tick(8);
      if (i < 24) rx[23-i] = sdo;
      sclk = 1'b1;
      tick(8);
      sclk = 1'b0;
    end
    tick(8);
    cs_n = 1'b1;
    sdi = 1'b0;
    tick(10);
    if (nclk == 24) begin
      m_tf = 1'b0;
      m_resb = (tx == 24'hFFFFFF) ? 1'b0 : 1'b1;
    end else if (nclk != 0) m_tf = 1'b1;
  endtask

  task automatic full(input logic [23:0] tx, input logic [15:0] exp_data, input string tag);
    logic [23:0] rx;
    logic [23:0] e;
    e = {exp_stat(), exp_data};
    frame(tx, 24, rx);
    chk(rx == e, tag, 32'(rx), 32'(e));
  endtask

  initial begin
    logic [23:0] rx;
    int w0, c0, r0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    chk(sdo_oe == 1'b0, "R2 reset hi-z", 32'(sdo_oe), 0);
    chk(reg_wr == 1'b0 && stat_clr == 1'b0, "R1 reset no strobe", 32'({reg_wr, stat_clr}), 0);

    // zero-clock poll
    frame(24'h0, 0, rx);
    chk(rx[23] == 1'b1, "R2 FLT poll", 32'(rx[23]), 1);
    chk(n_wr == 0 && n_rst == 0, "R9 zero-clock no strobe", 32'(n_wr + n_rst), 0);

    full(24'h45_0000, 16'hA005, "R3 reset status 81 / R5 read");
    chk(n_wr == 0 && n_clr == 0, "R5 read no strobe", 32'(n_wr + n_clr), 0);
    flags = 5'b00000;
    full(24'h45_0000, 16'hA005, "R11 RESB set status 20");

    full(24'h05_1234, 16'hA005, "R4 write returns old");
    chk(n_wr == 1, "R4 one write strobe", 32'(n_wr), 1);
    full(24'h45_0000, 16'h1234, "R4 write landed");

    full(24'h90_0000, 16'hA010, "R6 read-and-clear reply");
    chk(n_clr == 1 && n_wr == 1, "R6 one clear strobe", 32'(n_clr), 1);
    full(24'h50_0000, 16'h0000, "R6 register cleared");

    full(24'hFE_0000, 16'h0200, "R7 width id");
    full(24'hFD_0000, 16'h0000, "R7 other id");
    chk(n_wr == 1 && n_clr == 1, "R7 no strobe", 32'(n_wr + n_clr), 2);

    w0 = n_wr;
    frame(24'h05_5555, 10, rx);
    chk(n_wr == w0, "R8 short frame ignored", 32'(n_wr), 32'(w0));
    full(24'h45_0000, 16'h1234, "R8 TF reported E0");
    full(24'h45_0000, 16'h1234, "R8 TF cleared");

    frame(24'h05_7777, 25, rx);
    chk(n_wr == w0, "R8 long frame ignored", 32'(n_wr), 32'(w0));
    full(24'h45_0000, 16'h1234, "R8 TF after 25 clocks");

    frame(24'h0, 0, rx);
    full(24'h45_0000, 16'h1234, "R9 zero-clock leaves TF clear");

    w0 = n_wr; c0 = n_clr; r0 = n_rst;
    full(24'hFFFFFF, 16'h0000, "R10 all-ones reply");
    chk(n_rst == r0 + 1 && n_wr == w0 && n_clr == c0, "R10 reset pulse only", 32'(n_rst - r0), 1);
    full(24'h45_0000, 16'h1234, "R10 RESB cleared 80");
    full(24'h45_0000, 16'h1234, "R11 RESB restored");

    flags = 5'b01000;
    frame(24'h0, 0, rx);
    chk(rx[23] == 1'b1, "R3 fault input drives FLT", 32'(rx[23]), 1);
    full(24'h45_0000, 16'h1234, "R3 fault in status A8");
    chk(n_wr == w0 && n_clr == c0, "R1 no stray strobe", 32'(n_wr + n_clr), 32'(w0 + c0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule